// File: doc/BRIEF.md
# Eight-Function 64-bit Arithmetic and Logic Unit

This block is a 64-bit arithmetic and logic unit driven by two operands and a 3-bit operation code. The code picks one of four bitwise logic functions or one of four arithmetic functions. It returns a 64-bit result and a carry flag.

All four arithmetic functions run through a single carry-select adder. A small decoder steers the adder's second input and carry-in for each function. The second input can be B as given, B inverted, all zeros or all ones.

An output register stage is on by default (`REG_OUT = 1`), so results appear one clock after the inputs. With `REG_OUT = 0` the path is purely combinational. Arithmetic wraps modulo 2^64 and never saturates.

Top module: `alu64`

## Requirements
- R1: With `opSel[2]` = 0, the result is the bitwise function chosen by the code: 3'b000 gives A AND B, 3'b001 gives A XNOR B, 3'b010 gives A XOR B, and 3'b011 gives A OR B.
- R2: For every code with `opSel[2]` = 0, `carryOut` is 0.
- R3: Code 3'b100 gives (A + B) mod 2^64. `carryOut` is bit 64 of the unsigned 65-bit sum.
- R4: Code 3'b101 gives (A − B) mod 2^64, formed as A + ~B + 1. `carryOut` is 1 exactly when A ≥ B as unsigned numbers, meaning no borrow.
- R5: Code 3'b110 gives (A + 1) mod 2^64. B has no effect on it. `carryOut` is 1 only when A is all ones.
- R6: Code 3'b111 gives (A − 1) mod 2^64, formed as A plus all ones. B has no effect on it. `carryOut` is 0 only when A is zero.
- R7: With `REG_OUT` = 1, `result` and `carryOut` reflect the inputs sampled at the previous rising clock edge. Input changes between edges do not reach the outputs.
- R8: While `rstN` is low, the registered `result` is 0 and `carryOut` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rstN | input | 1 | Active-low synchronous reset of the output register |
| opA | input | 64 | First operand |
| opB | input | 64 | Second operand; ignored by increment and decrement |
| opSel | input | 3 | Operation code |
| result | output | 64 | Operation result |
| carryOut | output | 1 | Adder carry for arithmetic codes, 0 for logic codes |

## Verification
Every result and carry is due exactly one rising edge after its operands and code are applied, since the output register is the only stage on the path. The bench drives each vector on a falling edge and pushes the reference answer into a queue. It pops and compares that answer at the next falling edge. One nanosecond after each drive, it also confirms that the outputs still hold the previous vector's answer, which shows nothing leaks through before the edge.

// File: rtl/alu64_pkg.sv
package alu64_pkg;

  typedef enum logic [2:0] {
    OP_AND  = 3'b000,
    OP_XNOR = 3'b001,
    OP_XOR  = 3'b010,
    OP_OR   = 3'b011,
    OP_ADD  = 3'b100,
    OP_SUB  = 3'b101,
    OP_INC  = 3'b110,
    OP_DEC  = 3'b111
  } aluOp_e;

  typedef enum logic [1:0] {
    LG_AND  = 2'd0,
    LG_XNOR = 2'd1,
    LG_XOR  = 2'd2,
    LG_OR   = 2'd3
  } logicFn_e;

  typedef enum logic [1:0] {
    BSRC_PASS = 2'd0,
    BSRC_INV  = 2'd1,
    BSRC_ZERO = 2'd2,
    BSRC_ONES = 2'd3
  } bSrc_e;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic     arithSel;
    bSrc_e    bSrc;
    logic     carryIn;
    logicFn_e logicFn;
  } aluCtrl_t;

endpackage

// File: rtl/alu64_rca.sv
// Ripple block built from mux-style full adders: y=a^b, s=y^c, co = y ? c : a
module alu64_rca #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] chain;

  always_comb begin
    chain[0] = cin;
    for (int i = 0; i < W; i++) begin
      sum[i]     = (a[i] ^ b[i]) ^ chain[i];
      chain[i+1] = (a[i] ^ b[i]) ? chain[i] : a[i];
    end
    cout = chain[W];
  end
endmodule

// File: rtl/alu64_csel.sv
module alu64_csel #(
  parameter int WIDTH = 64,
  parameter int BLK   = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  localparam int NBLK = WIDTH / BLK;

  logic [NBLK:0] blkCarry;
  assign blkCarry[0] = cin;

  for (genvar k = 0; k < NBLK; k++) begin : gBlk
    if (k == 0) begin : gFirst
      // First block sees the real carry-in directly
      alu64_rca #(.W(BLK)) uRca (
        .a(a[BLK-1:0]), .b(b[BLK-1:0]), .cin(blkCarry[0]),
        .sum(sum[BLK-1:0]), .cout(blkCarry[1])
      );
    end else begin : gSel
      logic [BLK-1:0] sumLo, sumHi;
      logic           coLo, coHi;
      alu64_rca #(.W(BLK)) uRca0 (
        .a(a[k*BLK +: BLK]), .b(b[k*BLK +: BLK]), .cin(1'b0),
        .sum(sumLo), .cout(coLo)
      );
      alu64_rca #(.W(BLK)) uRca1 (
        .a(a[k*BLK +: BLK]), .b(b[k*BLK +: BLK]), .cin(1'b1),
        .sum(sumHi), .cout(coHi)
      );
      assign sum[k*BLK +: BLK] = blkCarry[k] ? sumHi : sumLo;
      assign blkCarry[k+1]     = blkCarry[k] ? coHi  : coLo;
    end
  end

  assign cout = blkCarry[NBLK];
endmodule

// File: rtl/alu64_ctrl.sv
module alu64_ctrl
  import alu64_pkg::*;
(
  input  logic [2:0] opSel,
  output aluCtrl_t   ctrl
);
  always_comb begin
    ctrl.arithSel = opSel[2];
    ctrl.bSrc     = BSRC_PASS;
    ctrl.carryIn  = 1'b0;
    ctrl.logicFn  = logicFn_e'(opSel[1:0]);
    case (aluOp_e'(opSel))
      OP_SUB:  begin ctrl.bSrc = BSRC_INV;  ctrl.carryIn = 1'b1; end
      OP_INC:  begin ctrl.bSrc = BSRC_ZERO; ctrl.carryIn = 1'b1; end
      OP_DEC:  begin ctrl.bSrc = BSRC_ONES; ctrl.carryIn = 1'b0; end
      default: begin ctrl.bSrc = BSRC_PASS; ctrl.carryIn = 1'b0; end
    endcase
  end
endmodule

// File: rtl/alu64_dp.sv
module alu64_dp
  import alu64_pkg::*;
#(
  parameter int WIDTH = 64,
  parameter int BLK   = 4
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  aluCtrl_t         ctrl,
  output logic [WIDTH-1:0] dpResult,
  output logic             dpCarry
);
  logic [WIDTH-1:0] addB, addSum, logicOut;
  logic             addCout;

  always_comb begin
    case (ctrl.bSrc)
      BSRC_INV:  addB = ~opB;
      BSRC_ZERO: addB = '0;
      BSRC_ONES: addB = '1;
      default:   addB = opB;
    endcase
  end

  alu64_csel #(.WIDTH(WIDTH), .BLK(BLK)) uAdd (
    .a(opA), .b(addB), .cin(ctrl.carryIn), .sum(addSum), .cout(addCout)
  );

  always_comb begin
    case (ctrl.logicFn)
      LG_AND:  logicOut = opA & opB;
      LG_XNOR: logicOut = ~(opA ^ opB);
      LG_XOR:  logicOut = opA ^ opB;
      default: logicOut = opA | opB;
    endcase
  end

  assign dpResult = ctrl.arithSel ? addSum : logicOut;
  assign dpCarry  = ctrl.arithSel & addCout;
endmodule

// File: rtl/alu64.sv
module alu64
  import alu64_pkg::*;
#(
  parameter int WIDTH   = 64,
  parameter int BLK     = 4,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [2:0]       opSel,
  output logic [WIDTH-1:0] result,
  output logic             carryOut
);
  aluCtrl_t         ctrl;
  logic [WIDTH-1:0] dpResult;
  logic             dpCarry;

  alu64_ctrl uCtrl (.opSel(opSel), .ctrl(ctrl));

  alu64_dp #(.WIDTH(WIDTH), .BLK(BLK)) uDp (
    .opA(opA), .opB(opB), .ctrl(ctrl), .dpResult(dpResult), .dpCarry(dpCarry)
  );

  if (REG_OUT) begin : gReg
    always_ff @(posedge clk) begin
      if (!rstN) begin
        result   <= '0;
        carryOut <= 1'b0;
      end else begin
        result   <= dpResult;
        carryOut <= dpCarry;
      end
    end

    a_r2_logic_no_carry: assert property (@(posedge clk) disable iff (!rstN)
      !opSel[2] |=> !carryOut);
    a_r3_add_sum: assert property (@(posedge clk) disable iff (!rstN)
      (opSel == 3'b100) |=> {carryOut, result} == ({1'b0, $past(opA)} + {1'b0, $past(opB)}));
    a_r4_sub_borrow: assert property (@(posedge clk) disable iff (!rstN)
      (opSel == 3'b101) |=> carryOut == ($past(opA) >= $past(opB)));
    a_r5_inc_carry: assert property (@(posedge clk) disable iff (!rstN)
      (opSel == 3'b110) |=> carryOut == (&$past(opA)));
    a_r6_dec_carry: assert property (@(posedge clk) disable iff (!rstN)
      (opSel == 3'b111) |=> carryOut == (|$past(opA)));
    a_r8_reset_clear: assert property (@(posedge clk)
      !rstN |=> (result == '0) && !carryOut);
  end else begin : gComb
    assign result   = dpResult;
    assign carryOut = dpCarry;
  end
endmodule

// File: tb/alu64_test.sv
module alu64_test;
  localparam int W = 64;

  logic         clk = 1'b0;
  logic         rstN;
  logic [W-1:0] opA, opB;
  logic [2:0]   opSel;
  logic [W-1:0] result;
  logic         carryOut;

  always #5 clk = ~clk;

  alu64 uut (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .opSel(opSel),
    .result(result), .carryOut(carryOut)
  );

  typedef struct {
    logic [W-1:0] r;
    logic         c;
    logic [2:0]   s;
  } expect_t;

  expect_t      pend[$];
  int           nChecks = 0;
  int           nFail   = 0;
  logic [W-1:0] holdR;
  logic         holdC;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic string resTag(input logic [2:0] s);
    case (s)
      3'b100:  return "R3";
      3'b101:  return "R4";
      3'b110:  return "R5";
      3'b111:  return "R6";
      default: return "R1";
    endcase
  endfunction

  // Behavioural reference
  function automatic expect_t refModel(input logic [W-1:0] a, input logic [W-1:0] b,
                                       input logic [2:0] s);
    expect_t e;
    e.s = s;
    e.c = 1'b0;
    case (s)
      3'b000: e.r = a & b;
      3'b001: e.r = ~(a ^ b);
      3'b010: e.r = a ^ b;
      3'b011: e.r = a | b;
      3'b100: begin e.r = a + b; e.c = (a + b) < a; end
      3'b101: begin e.r = a - b; e.c = (a >= b); end
      3'b110: begin e.r = a + 1; e.c = (a == '1); end
      default: begin e.r = a - 1; e.c = (a != '0); end
    endcase
    return e;
  endfunction

  task automatic compareHead();
    expect_t e;
    if (pend.size() > 0) begin
      e = pend.pop_front();
      chk(result === e.r, resTag(e.s), "result", result, e.r);
      chk(carryOut === e.c, e.s[2] ? resTag(e.s) : "R2", "carry",
          {{(W-1){1'b0}}, carryOut}, {{(W-1){1'b0}}, e.c});
      holdR = e.r;
      holdC = e.c;
    end
  endtask

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic [2:0] s);
    @(negedge clk);
    compareHead();
    opA = a; opB = b; opSel = s;
    pend.push_back(refModel(a, b, s));
    #1;
    // R7: nothing reaches the outputs before the next rising edge
    chk(result === holdR && carryOut === holdC, "R7", "early change", result, holdR);
  endtask

  function automatic logic [W-1:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    logic [W-1:0] corners [4];
    corners[0] = '0;
    corners[1] = '1;
    corners[2] = {1'b1, {(W-1){1'b0}}};
    corners[3] = {{(W-1){1'b0}}, 1'b1};

    rstN = 1'b0; opA = '0; opB = '0; opSel = 3'b000;
    repeat (2) @(negedge clk);
    chk(result === '0 && carryOut === 1'b0, "R8", "reset state", result, '0);
    rstN = 1'b1;
    holdR = '0;
    holdC = 1'b0;

    for (int op = 0; op < 8; op++) begin
      for (int i = 0; i < 4; i++) begin
        for (int j = 0; j < 4; j++) apply(corners[i], corners[j], 3'(op));
      end
      for (int k = 0; k < 24; k++) apply(rnd64(), rnd64(), 3'(op));
    end
    // R5/R6: same A with different B must give identical results
    apply(64'h0123_4567_89AB_CDEF, '0, 3'b110);
    apply(64'h0123_4567_89AB_CDEF, '1, 3'b110);
    apply(64'h0123_4567_89AB_CDEF, '0, 3'b111);
    apply(64'h0123_4567_89AB_CDEF, '1, 3'b111);
    @(negedge clk);
    compareHead();

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    #2000000;
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule